// File: doc/BRIEF.md
# Command Stream Opcode Decoder

This block sits behind a command fetch stage and interprets a stream of packed 32-bit command words. Each word arrives through a valid/ready handshake. Header words carry a 4-bit opcode in bits 31:28. The decoder turns them, and the data words that follow them, into register-write transactions. Each transaction carries a class identifier, a register offset and a 32-bit data word.

The decoder keeps the current class and tracks how many data words the active opcode is still owed. For masked forms it also tracks which mask bits remain. Restart requests and gather requests produce no register write. Each appears as a one-cycle descriptor pulse on its own output, and the words a gather describes are left for a separate fetch engine. An opcode outside the implemented set halts the decoder until reset.

Top module: `csd_decoder`

## Requirements
- R1: After reset, `cmd_ready` is 1, `wr_valid`, `restart_valid`, `gather_valid` and `err` are 0, and the current class equals the `RESET_CLASS` parameter.
- R2: Opcode 4 (immediate) emits exactly one write and takes no data word. The write goes to the current class, with offset from bits 27:16 and data equal to bits 15:0 zero-extended to 32 bits.
- R3: Opcode 1 (incrementing) with count N in bits 15:0 and offset in bits 27:16 writes the next N data words to offset, offset+1, and so on. The offset is computed modulo 4096.
- R4: Opcode 2 (non-incrementing) with count N writes the next N data words all to the offset in bits 27:16. A count of 0 consumes no data word and emits no write, so the word 0x20000000 is a no-op.
- R5: Opcode 3 (masked) takes a 16-bit mask in bits 15:0 and an offset in bits 27:16. It consumes one data word per set mask bit, lowest bit first, and writes each word to offset plus that bit's index. A zero mask consumes nothing.
- R6: Opcode 0 (class select) loads the class from bits 15:6, the offset from bits 27:16 and a mask from bits 5:0. The new class applies to the words owed by its own mask, which follow the rule of R5, and to all later writes.
- R7: Opcode 5 (restart) emits a one-cycle `restart_valid` pulse with `restart_addr` equal to bits 27:0 shifted left by 4. It emits no write.
- R8: Opcode 6 (gather) emits a one-cycle descriptor with count from bits 13:0, a register-write flag from bit 15, an incrementing flag from bit 14 and an offset from bits 27:16. Opcode 12 (wide gather) emits a descriptor with count from bits 27:0 and the wide flag set. Neither emits a write, and the next word is decoded as a header.
- R9: Any opcode in 7..11 or 13..15 is consumed, sets `err`, and drops `cmd_ready` to 0. Both hold until reset, and no further write is emitted.
- R10: While `wr_valid` is 1 and `wr_ready` is 0, `cmd_ready` is 0 and the pending class, offset and data stay unchanged. No data word is lost or reordered under backpressure.
- R11: A word accepted while data is still owed is treated as data whatever its top four bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Decoder accepts the offered word this cycle |
| cmd_word | input | 32 | Command or data word |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Downstream takes the pending write |
| wr_class | output | 10 | Class of the pending write |
| wr_offset | output | 12 | Register offset of the pending write |
| wr_data | output | 32 | Data of the pending write |
| restart_valid | output | 1 | One-cycle restart request |
| restart_addr | output | 32 | Restart target address |
| gather_valid | output | 1 | One-cycle gather descriptor |
| gather_count | output | 28 | Words described by the gather |
| gather_offset | output | 12 | Register offset for a writing gather |
| gather_regwr | output | 1 | Gather words are register writes |
| gather_incr | output | 1 | Gather writes use incrementing offsets |
| gather_wide | output | 1 | Descriptor came from a wide gather |
| err | output | 1 | Sticky unimplemented-opcode flag |

## Verification
The bench builds the decoder with `RESET_CLASS` set to 5, so the reset class cannot be confused with a zeroed register. It keeps the fixed 12-bit offset and 16-bit mask widths. With these widths, a three-word incrementing burst starting at 0xFFE crosses the offset wrap, and a mask using bit 15 reaches the top of the index range. A pseudo-random `wr_ready` pattern stresses R10 across a long burst.

// File: rtl/csd_pkg.sv
// Package: field layout and shared types of the command stream decoder.
// Assumes a 32-bit command word with the opcode in the top nibble.
package csd_pkg;
    localparam int DATA_W   = 32;
    localparam int OP_W     = 4;
    localparam int OP_LSB   = DATA_W - OP_W;
    localparam int OFF_LSB  = 16;
    localparam int OFF_W    = OP_LSB - OFF_LSB;
    localparam int CLS_LSB  = 6;
    localparam int CLS_W    = OFF_LSB - CLS_LSB;
    localparam int SCM_W    = CLS_LSB;
    localparam int LOW_W    = OFF_LSB;
    localparam int MIDX_W   = $clog2(LOW_W);
    localparam int GSHORT_W = LOW_W - 2;
    localparam int GCNT_W   = OP_LSB;
    localparam int ADDR_SH  = DATA_W - GCNT_W;

    localparam logic [OP_W-1:0] OP_SETCLS  = 4'd0;
    localparam logic [OP_W-1:0] OP_INCR    = 4'd1;
    localparam logic [OP_W-1:0] OP_FIXED   = 4'd2;
    localparam logic [OP_W-1:0] OP_MASKED  = 4'd3;
    localparam logic [OP_W-1:0] OP_IMM     = 4'd4;
    localparam logic [OP_W-1:0] OP_RESTART = 4'd5;
    localparam logic [OP_W-1:0] OP_GATHER  = 4'd6;
    localparam logic [OP_W-1:0] OP_GWIDE   = 4'd12;

    typedef enum logic [1:0] {ST_HDR, ST_DATA, ST_HALT} st_e;
    typedef enum logic [1:0] {DM_INCR, DM_FIXED, DM_MASK} dm_e;
endpackage

// File: rtl/csd_hdr_decode.sv
// Header field extraction: slices a command word into its opcode fields.
// Purely combinational; assumes the caller decides if the word is a header.
module csd_hdr_decode
    import csd_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    output logic [OP_W-1:0]   op,
    output logic [OFF_W-1:0]  off,
    output logic [CLS_W-1:0]  cls,
    output logic [SCM_W-1:0]  scm,
    output logic [LOW_W-1:0]  low,
    output logic [GCNT_W-1:0] g_cnt,
    output logic              g_regwr,
    output logic              g_incr,
    output logic              g_wide
);
    // Field slicing shared by every opcode.
    always_comb begin
        op      = word[DATA_W-1:OP_LSB];
        off     = word[OP_LSB-1:OFF_LSB];
        cls     = word[OFF_LSB-1:CLS_LSB];
        scm     = word[SCM_W-1:0];
        low     = word[LOW_W-1:0];
        g_regwr = word[LOW_W-1];
        g_incr  = word[LOW_W-2];
        g_wide  = (op == OP_GWIDE);
        g_cnt   = g_wide ? word[GCNT_W-1:0]
                         : GCNT_W'(word[GSHORT_W-1:0]);
    end
endmodule

// File: rtl/csd_lowbit.sv
// Lowest-set-bit finder: index of the lowest set mask bit and the mask
// with that bit cleared. Assumes W is a power of two.
module csd_lowbit #(
    parameter int W = 16,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     mask,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     rest
);
    // Priority scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
    end

    // Clear the lowest set bit.
    assign rest = mask & (mask - W'(1));
endmodule

// File: rtl/csd_wr_slot.sv
// One-entry write output register. It holds class, offset and data stable
// while the consumer stalls. Assumes load only happens when empty or draining.
module csd_wr_slot #(
    parameter int CW = 10,
    parameter int OW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] in_cls,
    input  logic [OW-1:0] in_off,
    input  logic [DW-1:0] in_data,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [CW-1:0] out_cls,
    output logic [OW-1:0] out_off,
    output logic [DW-1:0] out_data
);
    // Valid flag: set on load, cleared when the consumer takes the entry.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (load)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    // Payload capture on load only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cls  <= '0;
            out_off  <= '0;
            out_data <= '0;
        end else if (load) begin
            out_cls  <= in_cls;
            out_off  <= in_off;
            out_data <= in_data;
        end
    end
endmodule

// File: rtl/csd_decoder.sv
// Command stream opcode decoder top. It accepts words, tracks the active
// opcode and the data still owed to it, and emits register writes and
// restart/gather descriptor pulses. Assumes the write consumer obeys
// valid/ready, and the descriptor consumers take pulses without stalling.
module csd_decoder
    import csd_pkg::*;
#(
    parameter int RESET_CLASS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DATA_W-1:0] cmd_word,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [CLS_W-1:0]  wr_class,
    output logic [OFF_W-1:0]  wr_offset,
    output logic [DATA_W-1:0] wr_data,
    output logic              restart_valid,
    output logic [DATA_W-1:0] restart_addr,
    output logic              gather_valid,
    output logic [GCNT_W-1:0] gather_count,
    output logic [OFF_W-1:0]  gather_offset,
    output logic              gather_regwr,
    output logic              gather_incr,
    output logic              gather_wide,
    output logic              err
);
    localparam logic [CLS_W-1:0] CLS_INIT = CLS_W'(RESET_CLASS);

    st_e              state, st_n;
    dm_e              mode, mode_n;
    logic [CLS_W-1:0] cur_cls, cls_n;
    logic [OFF_W-1:0] base_off, off_n;
    logic [LOW_W-1:0] remain, remain_n;
    logic [LOW_W-1:0] mask, mask_n;
    logic             take;

    logic [OP_W-1:0]   h_op;
    logic [OFF_W-1:0]  h_off;
    logic [CLS_W-1:0]  h_cls;
    logic [SCM_W-1:0]  h_scm;
    logic [LOW_W-1:0]  h_low;
    logic [GCNT_W-1:0] h_gcnt;
    logic              h_gregwr, h_gincr, h_gwide;

    logic [MIDX_W-1:0] m_idx;
    logic [LOW_W-1:0]  m_rest;

    logic              wl_load;
    logic [OFF_W-1:0]  wl_off;
    logic [DATA_W-1:0] wl_data;
    logic              rs_fire, gt_fire;

    csd_hdr_decode u_hdr (
        .word    (cmd_word),
        .op      (h_op),
        .off     (h_off),
        .cls     (h_cls),
        .scm     (h_scm),
        .low     (h_low),
        .g_cnt   (h_gcnt),
        .g_regwr (h_gregwr),
        .g_incr  (h_gincr),
        .g_wide  (h_gwide)
    );

    csd_lowbit #(.W(LOW_W)) u_lowbit (
        .mask (mask),
        .idx  (m_idx),
        .rest (m_rest)
    );

    csd_wr_slot #(.CW(CLS_W), .OW(OFF_W), .DW(DATA_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wl_load),
        .in_cls    (cur_cls),
        .in_off    (wl_off),
        .in_data   (wl_data),
        .out_ready (wr_ready),
        .out_valid (wr_valid),
        .out_cls   (wr_class),
        .out_off   (wr_offset),
        .out_data  (wr_data)
    );

    // Accept only while running and the write slot is free or draining.
    assign cmd_ready = (state != ST_HALT) && (!wr_valid || wr_ready);
    assign take      = cmd_valid && cmd_ready;
    assign err       = (state == ST_HALT);

    // Next-state and write-generation logic for one accepted word.
    always_comb begin
        st_n     = state;
        mode_n   = mode;
        cls_n    = cur_cls;
        off_n    = base_off;
        remain_n = remain;
        mask_n   = mask;
        wl_load  = 1'b0;
        wl_off   = base_off;
        wl_data  = cmd_word;
        rs_fire  = 1'b0;
        gt_fire  = 1'b0;
        if (take) begin
            unique case (state)
                ST_HDR: begin
                    unique case (h_op)
                        OP_SETCLS: begin
                            cls_n  = h_cls;
                            off_n  = h_off;
                            mask_n = LOW_W'(h_scm);
                            mode_n = DM_MASK;
                            if (h_scm != '0) st_n = ST_DATA;
                        end
                        OP_INCR, OP_FIXED: begin
                            off_n    = h_off;
                            remain_n = h_low;
                            mode_n   = (h_op == OP_INCR) ? DM_INCR : DM_FIXED;
                            if (h_low != '0) st_n = ST_DATA;
                        end
                        OP_MASKED: begin
                            off_n  = h_off;
                            mask_n = h_low;
                            mode_n = DM_MASK;
                            if (h_low != '0) st_n = ST_DATA;
                        end
                        OP_IMM: begin
                            wl_load = 1'b1;
                            wl_off  = h_off;
                            wl_data = DATA_W'(h_low);
                        end
                        OP_RESTART:          rs_fire = 1'b1;
                        OP_GATHER, OP_GWIDE: gt_fire = 1'b1;
                        default:             st_n    = ST_HALT;
                    endcase
                end
                ST_DATA: begin
                    wl_load = 1'b1;
                    unique case (mode)
                        DM_INCR: begin
                            wl_off   = base_off;
                            off_n    = base_off + OFF_W'(1);
                            remain_n = remain - LOW_W'(1);
                            if (remain == LOW_W'(1)) st_n = ST_HDR;
                        end
                        DM_FIXED: begin
                            wl_off   = base_off;
                            remain_n = remain - LOW_W'(1);
                            if (remain == LOW_W'(1)) st_n = ST_HDR;
                        end
                        default: begin
                            wl_off = base_off + OFF_W'(m_idx);
                            mask_n = m_rest;
                            if (m_rest == '0) st_n = ST_HDR;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Decoder context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HDR;
            mode     <= DM_INCR;
            cur_cls  <= CLS_INIT;
            base_off <= '0;
            remain   <= '0;
            mask     <= '0;
        end else begin
            state    <= st_n;
            mode     <= mode_n;
            cur_cls  <= cls_n;
            base_off <= off_n;
            remain   <= remain_n;
            mask     <= mask_n;
        end
    end

    // Restart descriptor pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_valid <= 1'b0;
            restart_addr  <= '0;
        end else begin
            restart_valid <= rs_fire;
            if (rs_fire) restart_addr <= {cmd_word[GCNT_W-1:0], {ADDR_SH{1'b0}}};
        end
    end

    // Gather descriptor pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gather_valid  <= 1'b0;
            gather_count  <= '0;
            gather_offset <= '0;
            gather_regwr  <= 1'b0;
            gather_incr   <= 1'b0;
            gather_wide   <= 1'b0;
        end else begin
            gather_valid <= gt_fire;
            if (gt_fire) begin
                gather_count  <= h_gcnt;
                gather_wide   <= h_gwide;
                gather_offset <= h_gwide ? '0 : h_off;
                gather_regwr  <= !h_gwide && h_gregwr;
                gather_incr   <= !h_gwide && h_gincr;
            end
        end
    end
endmodule

// File: rtl/csd_decoder_chk.sv
// Checker: protocol properties of the decoder ports, bound to the top.
module csd_decoder_chk
    import csd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [CLS_W-1:0]  wr_class,
    input logic [OFF_W-1:0]  wr_offset,
    input logic [DATA_W-1:0] wr_data,
    input logic              restart_valid,
    input logic              gather_valid,
    input logic              err
);
    // R9: a halted decoder refuses words.
    p_halt_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !cmd_ready);

    // R9: the error flag stays until reset.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R10: a stalled write keeps its payload.
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_class)
                                     && $stable(wr_offset) && $stable(wr_data)));

    // R10: no word accepted while the write is stalled.
    p_stall_noaccept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> !cmd_ready);

    // R7: a restart follows an accepted word.
    p_restart_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |-> $past(cmd_valid && cmd_ready));

    // R8: a gather follows an accepted word and never coincides with a restart.
    p_gather_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gather_valid |-> ($past(cmd_valid && cmd_ready)
                          && $onehot0({gather_valid, restart_valid})));
endmodule

bind csd_decoder csd_decoder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_class      (wr_class),
    .wr_offset     (wr_offset),
    .wr_data       (wr_data),
    .restart_valid (restart_valid),
    .gather_valid  (gather_valid),
    .err           (err)
);

// File: tb/csd_decoder_tb.sv
`timescale 1ns/1ps
// Directed bench for the command stream decoder; one task per scenario.
module csd_decoder_tb;
    import csd_pkg::*;

    localparam int RCLS = 5;
    localparam int WD_LIMIT = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [DATA_W-1:0] cmd_word = '0;
    logic              wr_valid;
    logic              wr_ready;
    logic [CLS_W-1:0]  wr_class;
    logic [OFF_W-1:0]  wr_offset;
    logic [DATA_W-1:0] wr_data;
    logic              restart_valid;
    logic [DATA_W-1:0] restart_addr;
    logic              gather_valid;
    logic [GCNT_W-1:0] gather_count;
    logic [OFF_W-1:0]  gather_offset;
    logic              gather_regwr, gather_incr, gather_wide;
    logic              err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit hold_low = 0;
    bit bp_mode  = 0;
    logic [7:0] lfsr = 8'hA5;

    logic [CLS_W-1:0]  obs_cls  [256];
    logic [OFF_W-1:0]  obs_off  [256];
    logic [DATA_W-1:0] obs_data [256];
    int obs_n = 0;
    int cyc = 0;

    csd_decoder #(.RESET_CLASS(RCLS)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_word      (cmd_word),
        .wr_valid      (wr_valid),
        .wr_ready      (wr_ready),
        .wr_class      (wr_class),
        .wr_offset     (wr_offset),
        .wr_data       (wr_data),
        .restart_valid (restart_valid),
        .restart_addr  (restart_addr),
        .gather_valid  (gather_valid),
        .gather_count  (gather_count),
        .gather_offset (gather_offset),
        .gather_regwr  (gather_regwr),
        .gather_incr   (gather_incr),
        .gather_wide   (gather_wide),
        .err           (err)
    );

    always #2.5 clk = ~clk;

    // Consumer ready: driven just after each rising edge.
    initial wr_ready = 1'b1;
    always @(posedge clk) begin
        #1;
        lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        wr_ready = hold_low ? 1'b0 : (bp_mode ? lfsr[0] : 1'b1);
    end

    // Write monitor: records each handshake at the falling edge before it.
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            obs_cls[obs_n % 256]  = wr_class;
            obs_off[obs_n % 256]  = wr_offset;
            obs_data[obs_n % 256] = wr_data;
            obs_n = obs_n + 1;
        end
    end

    // Watchdog: a hung run is reported as a failure.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WD_LIMIT && !done) begin
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [DATA_W-1:0] w);
        cmd_word  = w;
        cmd_valid = 1'b1;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic do_reset();
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic exp_wr(input int base, input int k, input logic [CLS_W-1:0] c,
                          input logic [OFF_W-1:0] o, input logic [DATA_W-1:0] d,
                          input string req);
        int s = (base + k) % 256;
        chk(obs_cls[s] == c && obs_off[s] == o && obs_data[s] == d, req,
            $sformatf("write %0d cls/off/data", k),
            {10'(0), obs_cls[s], obs_off[s], obs_data[s]}, {10'(0), c, o, d});
    endtask

    task automatic exp_cnt(input int base, input int n, input string req);
        chk(obs_n - base == n, req, "write count", 64'(obs_n - base), 64'(n));
    endtask

    // R1, R2: reset state and immediate write with the reset class.
    task automatic t_reset_imm();
        int b;
        chk(cmd_ready && !wr_valid && !err && !restart_valid && !gather_valid, "R1",
            "ready/valid/err after reset",
            {cmd_ready, wr_valid, err, restart_valid, gather_valid}, 64'b10000);
        b = obs_n;
        send(32'h4123BEEF);
        idle(3);
        exp_cnt(b, 1, "R2");
        exp_wr(b, 0, CLS_W'(RCLS), 12'h123, 32'h0000BEEF, "R1 R2");
    endtask

    // R3, R11: incrementing burst wrapping the offset, data that looks like a header.
    task automatic t_incr();
        int b = obs_n;
        send(32'h1FFE0003);
        send(32'h40000000);
        send(32'h0000000A);
        send(32'h0000000B);
        send(32'h40050007);
        idle(3);
        exp_cnt(b, 4, "R3");
        exp_wr(b, 0, CLS_W'(RCLS), 12'hFFE, 32'h40000000, "R3 R11");
        exp_wr(b, 1, CLS_W'(RCLS), 12'hFFF, 32'h0000000A, "R3");
        exp_wr(b, 2, CLS_W'(RCLS), 12'h000, 32'h0000000B, "R3");
        exp_wr(b, 3, CLS_W'(RCLS), 12'h005, 32'h00000007, "R3 R2");
    endtask

    // R4: fixed-offset burst and the no-op word.
    task automatic t_fixed();
        int b = obs_n;
        send(32'h20200002);
        send(32'h11111111);
        send(32'h22222222);
        send(32'h20000000);
        send(32'h40010001);
        idle(3);
        exp_cnt(b, 3, "R4");
        exp_wr(b, 0, CLS_W'(RCLS), 12'h020, 32'h11111111, "R4");
        exp_wr(b, 1, CLS_W'(RCLS), 12'h020, 32'h22222222, "R4");
        exp_wr(b, 2, CLS_W'(RCLS), 12'h001, 32'h00000001, "R4 nop");
    endtask

    // R5: masked write with bits 0, 2, 15, then an empty mask.
    task automatic t_mask();
        int b = obs_n;
        send(32'h30108005);
        send(32'hD0D0D0D0);
        send(32'hD1D1D1D1);
        send(32'hD2D2D2D2);
        send(32'h30100000);
        send(32'h40020002);
        idle(3);
        exp_cnt(b, 4, "R5");
        exp_wr(b, 0, CLS_W'(RCLS), 12'h010, 32'hD0D0D0D0, "R5");
        exp_wr(b, 1, CLS_W'(RCLS), 12'h012, 32'hD1D1D1D1, "R5");
        exp_wr(b, 2, CLS_W'(RCLS), 12'h01F, 32'hD2D2D2D2, "R5");
        exp_wr(b, 3, CLS_W'(RCLS), 12'h002, 32'h00000002, "R5 zero mask");
    endtask

    // R6: class select with mask bits 1 and 5, then one with no mask.
    task automatic t_setcls();
        int b = obs_n;
        send(32'h0040A962);
        send(32'hC0C0C0C0);
        send(32'hC1C1C1C1);
        send(32'h40070009);
        send(32'h00000040);
        send(32'h40080008);
        idle(3);
        exp_cnt(b, 4, "R6");
        exp_wr(b, 0, 10'h2A5, 12'h041, 32'hC0C0C0C0, "R6");
        exp_wr(b, 1, 10'h2A5, 12'h045, 32'hC1C1C1C1, "R6");
        exp_wr(b, 2, 10'h2A5, 12'h007, 32'h00000009, "R6");
        exp_wr(b, 3, 10'h001, 12'h008, 32'h00000008, "R6 no mask");
    endtask

    // R7: restart descriptor.
    task automatic t_restart();
        int b = obs_n;
        send(32'h5ABCDEF1);
        chk(restart_valid && !gather_valid && restart_addr == 32'hABCDEF10, "R7",
            "restart pulse/addr", {restart_valid, restart_addr}, {1'b1, 32'hABCDEF10});
        idle(1);
        chk(!restart_valid, "R7", "restart one cycle", 64'(restart_valid), 64'd0);
        idle(2);
        exp_cnt(b, 0, "R7");
    endtask

    // R8: gather, plain gather and wide gather descriptors.
    task automatic t_gather();
        int b = obs_n;
        send(32'h6033C00A);
        chk(gather_valid && gather_count == 28'hA && gather_offset == 12'h033
            && gather_regwr && gather_incr && !gather_wide, "R8", "writing gather",
            {gather_valid, gather_count, gather_offset, gather_regwr, gather_incr, gather_wide},
            {1'b1, 28'hA, 12'h033, 1'b1, 1'b1, 1'b0});
        send(32'h60000005);
        chk(gather_valid && gather_count == 28'h5 && !gather_regwr && !gather_incr
            && !gather_wide, "R8", "plain gather",
            {gather_valid, gather_count, gather_regwr, gather_incr, gather_wide},
            {1'b1, 28'h5, 1'b0, 1'b0, 1'b0});
        send(32'hC1234567);
        chk(gather_valid && gather_count == 28'h1234567 && gather_wide, "R8", "wide gather",
            {gather_valid, gather_count, gather_wide}, {1'b1, 28'h1234567, 1'b1});
        send(32'h40030003);
        idle(3);
        exp_cnt(b, 1, "R8");
        exp_wr(b, 0, 10'h001, 12'h003, 32'h00000003, "R8 header after gather");
    endtask

    // R10: held stall, then a random-ready burst.
    task automatic t_backpressure();
        int b = obs_n;
        hold_low = 1;
        idle(1);
        send(32'h400A00AA);
        cmd_word  = 32'h400B00BB;
        cmd_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!cmd_ready && wr_valid && wr_data == 32'hAA && wr_offset == 12'h00A, "R10",
                "stall holds write", {cmd_ready, wr_valid, wr_data}, {1'b0, 1'b1, 32'hAA});
        end
        hold_low = 0;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        bp_mode = 1;
        send(32'h10400008);
        for (int i = 0; i < 8; i++) send(32'hF000_0000 + 32'(i));
        idle(40);
        bp_mode = 0;
        idle(2);
        exp_cnt(b, 10, "R10");
        exp_wr(b, 0, 10'h001, 12'h00A, 32'h000000AA, "R10");
        exp_wr(b, 1, 10'h001, 12'h00B, 32'h000000BB, "R10");
        for (int i = 0; i < 8; i++)
            exp_wr(b, 2 + i, 10'h001, 12'h040 + 12'(i), 32'hF000_0000 + 32'(i), "R10 R11");
    endtask

    // R9: unimplemented opcodes halt until reset.
    task automatic t_error();
        int b = obs_n;
        send(32'h70000000);
        idle(1);
        chk(err && !cmd_ready && !wr_valid, "R9", "halt after opcode 7",
            {err, cmd_ready, wr_valid}, 3'b100);
        cmd_word  = 32'h40010001;
        cmd_valid = 1'b1;
        idle(5);
        cmd_valid = 1'b0;
        chk(err && !cmd_ready, "R9", "halt sticky", {err, cmd_ready}, 2'b10);
        exp_cnt(b, 0, "R9");
        do_reset();
        chk(!err && cmd_ready, "R9 R1", "reset clears halt", {err, cmd_ready}, 2'b01);
        send(32'hD0000000);
        idle(1);
        chk(err && !cmd_ready, "R9", "halt after opcode 13", {err, cmd_ready}, 2'b10);
    endtask

    initial begin
        do_reset();
        t_reset_imm();
        t_incr();
        t_fixed();
        t_mask();
        t_setcls();
        t_restart();
        t_gather();
        t_backpressure();
        t_error();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule